// File: doc/BRIEF.md
# Serial Reflected CRC-32 Engine

This block keeps a 32-bit cyclic redundancy check over a serial stream that arrives least-significant bit first, one bit for each clock in which the bit enable is high. The register shifts right, in the same direction as the data. This keeps the feedback to one XOR row and one compare of the arriving bit against register bit 0. A burst starts with an initialise strobe. The check then runs over every word of the burst, whether the words are 8, 16 or 32 bits long, and is never reset between words.

The same register serves the two other halves of a link. In emit mode the register is shifted out LSB first on a serial output, with no final inversion. In compare mode it is shifted out while a received CRC arrives on the data input. A sticky flag records any differing bit, and after 32 compared bits the block reports match or mismatch.

Top module: `crc32_serial`

## Requirements
- R1: After reset, `crc_o` is 0xFFFFFFFF, and both `cmp_done_o` and `match_o` are 0.
- R2: A clock with `init_i` high loads `crc_o` with 0xFFFFFFFF and clears `cmp_done_o` and `match_o`. This holds even when `bit_en_i` is high in the same clock, and the bit offered in that clock has no effect.
- R3: In accumulate mode (`op_i` = 2'b00), each enabled clock shifts the register right by one place with a 0 entering bit 31. The result is XORed with 0xEDB88320 exactly when `data_i` differs from the old bit 0.
- R4: A clock with `bit_en_i` low, or with `op_i` = 2'b11, changes none of `crc_o`, `cmp_done_o` and `match_o`.
- R5: The check runs on across successive words of 8, 16 or 32 bits, each word fed LSB first. The same bit stream gives the same result whatever the word split. For the ASCII bytes "123456789", `crc_o` ends at 0x340BC6D9, with no final inversion.
- R6: `ser_o` always equals `crc_o[0]`. In emit mode (`op_i` = 2'b01), each enabled clock shifts the register right with a 0 entering bit 31, so 32 emit bits send the whole CRC LSB first and leave the register at zero.
- R7: In compare mode (`op_i` = 2'b10), each enabled clock shifts the register as in emit mode and compares `data_i` with the old bit 0. `cmp_done_o` rises after the 32nd compared bit. `match_o` then equals 1 only if no compared bit differed since the last initialise.
- R8: Once `cmp_done_o` is 1, further compare-mode bits change neither the register nor the flags until the next initialise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| init_i | input | 1 | Burst start: load the initial value and clear the compare state |
| bit_en_i | input | 1 | One serial bit is present this clock |
| op_i | input | 2 | 00 accumulate, 01 emit, 10 compare, 11 no operation |
| data_i | input | 1 | Serial data bit, or received CRC bit in compare mode |
| crc_o | output | 32 | Running CRC register |
| ser_o | output | 1 | Serial CRC bit (register bit 0) |
| cmp_done_o | output | 1 | 32 compare bits have been taken |
| match_o | output | 1 | Compare complete with no differing bit |

## Verification
Every result is registered, so the register, done flag and match flag all change on the edge that samples an enabled bit, and are due one clock after the stimulus. The bench drives inputs on the falling edge, takes that one rising edge, and checks at the following falling edge. `ser_o` follows the register with no delay, so each emitted and compared bit is checked on the falling edge before the bit that consumes it is clocked in. All 256 single-byte bursts are swept against an arithmetic model in the bench, together with word-split equivalence, the full emit and compare sequences, and the saturated compare state.

// File: rtl/crc32s_pkg.sv
package crc32s_pkg;
  parameter int CRC_W = 32;

  typedef enum logic [1:0] {
    OP_ACC  = 2'b00,
    OP_EMIT = 2'b01,
    OP_CMP  = 2'b10,
    OP_NONE = 2'b11
  } crc_op_e;

  // One reflected step: shift toward bit 0, fold the polynomial in on feedback.
  function automatic logic [CRC_W-1:0] refl_step(input logic [CRC_W-1:0] cur,
                                                 input logic fb,
                                                 input logic [CRC_W-1:0] poly);
    return (cur >> 1) ^ ({CRC_W{fb}} & poly);
  endfunction
endpackage

// File: rtl/crc32s_reg.sv
module crc32s_reg
  import crc32s_pkg::*;
#(
  parameter logic [CRC_W-1:0] POLY = 32'hEDB88320,
  parameter logic [CRC_W-1:0] INIT = 32'hFFFFFFFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             adv_i,
  input  logic             use_fb_i,
  input  logic             data_i,
  output logic [CRC_W-1:0] crc_q
);
  logic fb;
  assign fb = use_fb_i & (data_i ^ crc_q[0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      crc_q <= INIT;
    else if (load_i) crc_q <= INIT;
    else if (adv_i)  crc_q <= refl_step(crc_q, fb, POLY);
  end

  AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> crc_q == INIT); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !adv_i) |=> $stable(crc_q)); // R4
  AST_TOP_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && adv_i && POLY[CRC_W-1]) |=> crc_q[CRC_W-1] == $past(fb)); // R3
  AST_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && adv_i && !use_fb_i) |=> !crc_q[CRC_W-1]); // R6
endmodule

// File: rtl/crc32s_cmp.sv
module crc32s_cmp
  import crc32s_pkg::*;
#(
  parameter int NBITS = CRC_W,
  localparam int CW = $clog2(NBITS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic take_i,
  input  logic miss_i,
  output logic done_o,
  output logic bad_o
);
  logic [CW-1:0] cnt_q;

  assign done_o = (cnt_q == CW'(NBITS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      bad_o <= 1'b0;
    end else if (clr_i) begin
      cnt_q <= '0;
      bad_o <= 1'b0;
    end else if (take_i && !done_o) begin
      cnt_q <= cnt_q + 1'b1;
      bad_o <= bad_o | miss_i;
    end
  end

  AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(NBITS)); // R8
  AST_MISS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_o && !clr_i) |=> bad_o); // R7
  AST_DONE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !clr_i) |=> (done_o && $stable(bad_o))); // R8
endmodule

// File: rtl/crc32_serial.sv
module crc32_serial
  import crc32s_pkg::*;
#(
  parameter logic [CRC_W-1:0] POLY = 32'hEDB88320,
  parameter logic [CRC_W-1:0] INIT = 32'hFFFFFFFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init_i,
  input  logic             bit_en_i,
  input  logic [1:0]       op_i,
  input  logic             data_i,
  output logic [CRC_W-1:0] crc_o,
  output logic             ser_o,
  output logic             cmp_done_o,
  output logic             match_o
);
  crc_op_e op;
  logic    cmp_full;
  logic    cmp_bad;
  logic    acc_fire, emit_fire, cmp_fire, reg_adv;

  assign op        = crc_op_e'(op_i);
  assign acc_fire  = bit_en_i && !init_i && (op == OP_ACC);
  assign emit_fire = bit_en_i && !init_i && (op == OP_EMIT);
  assign cmp_fire  = bit_en_i && !init_i && (op == OP_CMP) && !cmp_full;
  assign reg_adv   = acc_fire | emit_fire | cmp_fire;

  crc32s_reg #(.POLY(POLY), .INIT(INIT)) u_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (init_i),
    .adv_i    (reg_adv),
    .use_fb_i (acc_fire),
    .data_i   (data_i),
    .crc_q    (crc_o)
  );

  crc32s_cmp #(.NBITS(CRC_W)) u_cmp (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (init_i),
    .take_i (cmp_fire),
    .miss_i (data_i ^ crc_o[0]),
    .done_o (cmp_full),
    .bad_o  (cmp_bad)
  );

  assign ser_o      = crc_o[0];
  assign cmp_done_o = cmp_full;
  assign match_o    = cmp_full & ~cmp_bad;

  AST_ONE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({acc_fire, emit_fire, cmp_fire})); // R4
  AST_MATCH_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    match_o |-> cmp_done_o); // R7
  AST_INIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    init_i |=> (!cmp_done_o && !match_o)); // R2
endmodule

// File: tb/sim_crc32_serial.sv
module sim_crc32_serial;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        init_i = 1'b0;
  logic        bit_en_i = 1'b0;
  logic [1:0]  op_i = 2'b00;
  logic        data_i = 1'b0;
  logic [31:0] crc_o;
  logic        ser_o, cmp_done_o, match_o;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  crc32_serial u0 (
    .clk(clk), .rst_n(rst_n), .init_i(init_i), .bit_en_i(bit_en_i),
    .op_i(op_i), .data_i(data_i), .crc_o(crc_o), .ser_o(ser_o),
    .cmp_done_o(cmp_done_o), .match_o(match_o)
  );

  // Bench model: test old bit 0 against the data bit, then shift and fold.
  function automatic logic [31:0] model_bit(input logic [31:0] c, input logic b);
    logic [31:0] n;
    n = {1'b0, c[31:1]};
    if (c[0] != b) n = n ^ 32'hEDB88320;
    return n;
  endfunction

  function automatic logic [31:0] model_word(input logic [31:0] c, input logic [31:0] w, input int n);
    logic [31:0] r;
    r = c;
    for (int k = 0; k < n; k++) r = model_bit(r, w[k]);
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse(input logic ini, input logic en, input logic [1:0] op, input logic d);
    init_i = ini; bit_en_i = en; op_i = op; data_i = d;
    @(posedge clk);
    @(negedge clk);
    init_i = 1'b0; bit_en_i = 1'b0;
  endtask

  task automatic feed(input logic [31:0] w, input int n);
    for (int k = 0; k < n; k++) pulse(1'b0, 1'b1, 2'b00, w[k]);
  endtask

  initial begin
    #20000000;
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] exp, snap;
    logic [7:0]  msg [9];
    for (int k = 0; k < 9; k++) msg[k] = 8'h31 + 8'(k);

    repeat (3) @(negedge clk);
    check("R1 crc", crc_o, 32'hFFFFFFFF);
    check("R1 flags", {30'd0, cmp_done_o, match_o}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3: single steps from the initial value, both feedback cases
    pulse(1'b0, 1'b1, 2'b00, 1'b1);
    check("R3 no fold", crc_o, 32'h7FFFFFFF);
    pulse(1'b1, 1'b0, 2'b00, 1'b0);
    pulse(1'b0, 1'b1, 2'b00, 1'b0);
    check("R3 fold", crc_o, 32'h7FFFFFFF ^ 32'hEDB88320);

    // R4: enable low and the no-operation code hold everything
    snap = crc_o;
    pulse(1'b0, 1'b0, 2'b00, 1'b1);
    check("R4 en low", crc_o, snap);
    pulse(1'b0, 1'b1, 2'b11, 1'b1);
    check("R4 op 11", crc_o, snap);
    check("R4 flags", {30'd0, cmp_done_o, match_o}, 32'd0);

    // R2: init wins over a same-clock enable
    pulse(1'b1, 1'b1, 2'b00, 1'b0);
    check("R2 init priority", crc_o, 32'hFFFFFFFF);

    // R3: exhaustive single-byte sweep
    for (int v = 0; v < 256; v++) begin
      pulse(1'b1, 1'b0, 2'b00, 1'b0);
      feed(32'(v), 8);
      check($sformatf("R3 byte %0d", v), crc_o, model_word(32'hFFFFFFFF, 32'(v), 8));
    end

    // R5: known string, bytewise
    pulse(1'b1, 1'b0, 2'b00, 1'b0);
    for (int k = 0; k < 9; k++) feed({24'd0, msg[k]}, 8);
    check("R5 bytes", crc_o, 32'h340BC6D9);

    // R5: same 8 bytes as 16-bit and 32-bit words
    exp = 32'hFFFFFFFF;
    for (int k = 0; k < 8; k++) exp = model_word(exp, {24'd0, msg[k]}, 8);
    pulse(1'b1, 1'b0, 2'b00, 1'b0);
    for (int k = 0; k < 8; k += 2) feed({16'd0, msg[k+1], msg[k]}, 16);
    check("R5 halfwords", crc_o, exp);
    pulse(1'b1, 1'b0, 2'b00, 1'b0);
    for (int k = 0; k < 8; k += 4) feed({msg[k+3], msg[k+2], msg[k+1], msg[k]}, 32);
    check("R5 words", crc_o, exp);

    // R6: emit the whole register LSB first
    snap = crc_o;
    for (int k = 0; k < 32; k++) begin
      check($sformatf("R6 ser bit %0d", k), {31'd0, ser_o}, {31'd0, snap[k]});
      pulse(1'b0, 1'b1, 2'b01, 1'b1);
    end
    check("R6 drained", crc_o, 32'd0);

    // R7: compare against the correct value
    pulse(1'b1, 1'b0, 2'b00, 1'b0);
    for (int k = 0; k < 9; k++) feed({24'd0, msg[k]}, 8);
    snap = crc_o;
    for (int k = 0; k < 32; k++) begin
      check($sformatf("R7 cmp ser %0d", k), {31'd0, ser_o}, {31'd0, snap[k]});
      if (k == 31) check("R7 not done at 31", {31'd0, cmp_done_o}, 32'd0);
      pulse(1'b0, 1'b1, 2'b10, snap[k]);
    end
    check("R7 good done", {30'd0, cmp_done_o, match_o}, 32'd3);

    // R8: extra compare bits after done are ignored
    pulse(1'b0, 1'b1, 2'b10, 1'b1);
    check("R8 frozen crc", crc_o, 32'd0);
    check("R8 frozen flags", {30'd0, cmp_done_o, match_o}, 32'd3);

    // R2: init clears the compare state
    pulse(1'b1, 1'b0, 2'b00, 1'b0);
    check("R2 flags cleared", {30'd0, cmp_done_o, match_o}, 32'd0);

    // R7: one flipped bit gives a mismatch
    for (int k = 0; k < 9; k++) feed({24'd0, msg[k]}, 8);
    for (int k = 0; k < 32; k++) pulse(1'b0, 1'b1, 2'b10, snap[k] ^ (k == 5));
    check("R7 bad done", {30'd0, cmp_done_o, match_o}, 32'd2);
    check("R7 bad drained", crc_o, 32'd0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule